// File: doc/BRIEF.md
# Segmented Address Translator

This block turns 32-bit segmented addresses into physical memory addresses. A segmented address names one of sixteen segments in a 4-bit field and carries a byte offset in its low 24 bits. The block looks up the base address of the named segment in an internal table, adds the offset, and returns the sum as a physical address. The downstream engines use that address directly, with no further mapping.

Software fills the base table through a write port that takes an enable, a segment index and a 32-bit base value. Translation requests arrive with a valid strobe. The registered result appears one cycle later with its own valid strobe, and a new request can be accepted on every cycle. The four most significant address bits are masked off and play no part in the translation.

Top module: `seg_translator`

## Requirements
- R1: The block holds 16 segment bases. A request selects the entry given by req_addr bits 27:24. A write with wr_en high stores wr_base into entry wr_idx, and that value is used by every later lookup of that entry.
- R2: Bits 31:28 of req_addr have no effect on rsp_addr.
- R3: rsp_addr equals the selected base plus req_addr bits 23:0, zero-extended to 32 bits.
- R4: The addition wraps modulo 2^32, and any carry out of bit 31 is discarded.
- R5: When a write and a lookup name the same entry in the same cycle, the lookup uses the new wr_base.
- R6: Reset clears all 16 bases and drives rsp_valid low. After reset, any segment translates to its bare offset.
- R7: rsp_valid goes high exactly one cycle after req_valid and is low one cycle after req_valid is low. Requests on back-to-back cycles return one result per cycle.
- R8: rsp_addr keeps its value on cycles that follow a cycle with req_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Segment entry to write |
| wr_base | input | 32 | Base address to store |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Segmented address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Translated physical address |

## Verification
The bench sends the same offset and segment with every value of the top nibble. A design that decoded those bits would pick a different entry or add extra high bits to the sum. It loads a base near 2^32 and adds a large offset, so a design that kept the carry or used the wrong width would give a result other than the wrapped one. It writes and looks up the same entry in one cycle, which shows whether the design reads the stale base instead of forwarding the new one. It also checks idle cycles, where a design that reloaded its output register without a request would change rsp_addr. Long runs of back-to-back random requests show whether the design drops or delays results.

// File: rtl/seg_translator.sv
module seg_translator #(
  parameter int ADDR_W    = 32,
  parameter int SEG_COUNT = 16,
  parameter int SEG_LSB   = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(SEG_COUNT)-1:0] wr_idx,
  input  logic [ADDR_W-1:0]            wr_base,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         rsp_valid,
  output logic [ADDR_W-1:0]            rsp_addr
);
  localparam int IDX_W = $clog2(SEG_COUNT);
  localparam int OFF_W = SEG_LSB;

  logic [ADDR_W-1:0] base_q [SEG_COUNT];
  logic [IDX_W-1:0]  seg;
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] offset;

  assign seg      = req_addr[SEG_LSB +: IDX_W];
  assign offset   = {{(ADDR_W-OFF_W){1'b0}}, req_addr[OFF_W-1:0]};
  assign sel_base = (wr_en && wr_idx == seg) ? wr_base : base_q[seg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_COUNT; i++) base_q[i] <= '0;
    end else if (wr_en) begin
      base_q[wr_idx] <= wr_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_addr <= sel_base + offset;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_addr)); // R8
  AST_FORWARD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_en && wr_idx == seg) |=>
      rsp_addr == $past(wr_base) + {{(ADDR_W-OFF_W){1'b0}}, $past(req_addr[OFF_W-1:0])}); // R5
endmodule

// File: tb/sim_seg_translator.sv
module sim_seg_translator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [16];
  logic [31:0] exp_addr = '0;

  always #5 clk = ~clk;

  seg_translator u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
  );

  function automatic logic [31:0] xlat(input logic [31:0] base, input logic [31:0] a);
    return base + {8'h00, a[23:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] wi, input logic [31:0] wb,
                      input bit rv, input logic [31:0] ra, input string tag);
    logic [31:0] b;
    wr_en = we; wr_idx = wi; wr_base = wb; req_valid = rv; req_addr = ra;
    if (rv) begin
      b = (we && wi == ra[27:24]) ? wb : model[ra[27:24]];
      exp_addr = xlat(b, ra);
    end
    if (we) model[wi] = wb;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R7 valid"}, {31'b0, rsp_valid}, {31'b0, rv});
    check({tag, " addr"}, rsp_addr, exp_addr);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [31:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R6 valid low in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 valid low after reset", {31'b0, rsp_valid}, 32'd0);
    check("R6 addr zero after reset", rsp_addr, 32'd0);
    // R6: zero bases give identity on offset
    step(0, 0, 0, 1, 32'h0512_3456, "R6 identity seg5");
    check("R6 identity value", rsp_addr, 32'h0012_3456);
    step(0, 0, 0, 1, 32'h0000_00FF, "R6 identity seg0");
    // R1: load table, then read each entry
    for (int i = 0; i < 16; i++) step(1, 4'(i), 32'h1000_0000 * 32'(i) + 32'h100, 0, 0, "R1 load");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, {4'h0, 4'(i), 24'h000010}, "R1 R3 lookup");
    // R2: top nibble ignored
    for (int t = 0; t < 16; t++) begin
      step(0, 0, 0, 1, {4'(t), 4'h7, 24'hABCDEF}, "R2 top nibble");
      check("R2 value", rsp_addr, 32'h7000_0100 + 32'h00AB_CDEF);
    end
    // R4: wrap modulo 2^32
    step(1, 4'h3, 32'hFFFF_FFF0, 0, 0, "R4 load");
    step(0, 0, 0, 1, 32'h0300_0020, "R4 wrap");
    check("R4 wrapped value", rsp_addr, 32'h0000_0010);
    step(0, 0, 0, 1, 32'h03FF_FFFF, "R4 wrap max offset");
    // R5: same-cycle write and lookup
    step(1, 4'h9, 32'h2222_0000, 1, 32'h0900_0004, "R5 forward");
    check("R5 forward value", rsp_addr, 32'h2222_0004);
    step(1, 4'h9, 32'h3333_0000, 1, 32'h0A00_0004, "R5 other entry");
    step(0, 0, 0, 1, 32'h0900_0008, "R1 R5 stored after forward");
    check("R5 stored value", rsp_addr, 32'h3333_0008);
    // R8: hold during idle
    r = rsp_addr;
    step(0, 0, 0, 0, 32'h0F00_1234, "R8 idle");
    check("R8 hold 1", rsp_addr, r);
    step(1, 4'h0, 32'h4444_4444, 0, 32'h0000_0000, "R8 idle with write");
    check("R8 hold 2", rsp_addr, r);
    // R7: back-to-back random mix
    for (int n = 0; n < 2000; n++) begin
      a = $urandom;
      step(($urandom % 4) == 0, 4'($urandom), $urandom, ($urandom % 8) != 0, a, "R7 R3 random");
    end
    step(0, 0, 0, 0, 0, "R7 drain");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule